// File: doc/BRIEF.md
# Up/Down Code Stepper

This block changes a 12-bit converter code register using two step pins instead of the serial port. A falling edge on the raise pin adds one unit to a selected upper field of the code. A falling edge on the lower pin takes one unit away. A 2-bit granularity setting decides whether that field is the whole word, the upper ten bits or the upper eight bits. The bits below the field are never altered by a step, so software can load fine trim bits once and the pins then move only the coarse part.

The step pins, chip select and clear are treated as asynchronous. The step pins and chip select pass through two-flop synchronizers, and an edge detector follows them. Stepping is accepted only while chip select is high; when it is low the serial side owns the register. A clear input forces the code to zero at once, without waiting for a clock, unless the busy flag says the device is not yet ready. While clear is accepted, the block also drives a strobe that wipes the serial input register. A one-cycle pulse marks every step that changed the code.

Top module: `updn_code_stepper`

## Requirements
- R1: With granularity 2'b00, each accepted step adds or subtracts 1 at bit 0 of the 12-bit code.
- R2: With granularity 2'b01, each accepted step adds or subtracts 4, and code bits [1:0] keep their value.
- R3: With granularity 2'b10, each accepted step adds or subtracts 16, and code bits [3:0] keep their value.
- R4: With granularity 2'b11, step edges leave the code unchanged.
- R5: A high-to-low transition of `up_pin` while `dn_pin` is low is an increment. A high-to-low transition of `dn_pin` while `up_pin` is low is a decrement. A falling edge of one pin while the other pin is high causes no change.
- R6: While `cs_pin` is low, step edges leave the code unchanged.
- R7: The selected field stops at all ones on increment and at zero on decrement; it does not wrap.
- R8: With `busy` low, `clr_pin` high forces `code` to 000h without a clock edge and drives `ser_clr` high. With `busy` high, `clr_pin` has no effect and `ser_clr` stays low.
- R9: The new code and a one-cycle `chg` pulse appear on the third rising clock edge after a step pin's falling transition. A step that hits the saturation limit raises no pulse.
- R10: Step falling edges spaced four clock cycles apart are each accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_pin | input | 1 | Raise step pin, asynchronous |
| dn_pin | input | 1 | Lower step pin, asynchronous |
| cs_pin | input | 1 | Chip select, high enables stepping |
| clr_pin | input | 1 | Asynchronous clear of the code, active high |
| busy | input | 1 | High while the device is not ready; blocks clear |
| gran | input | 2 | Step granularity: 00 bit 0, 01 bit 2, 10 bit 4, 11 off |
| code | output | 12 | Current converter code |
| chg | output | 1 | One-cycle pulse after each step that changed the code |
| ser_clr | output | 1 | Clear strobe for the serial input register |

## Verification
The bench loads nonzero trim bits before it switches to the coarser granularities. A design that carried or masked into the low bits would show a wrong low nibble. It drives the eight-bit field up to its ceiling with pulses at the fastest spacing. A wrapping design would return to zero, and a slow detector would come up short of the step count. It holds one pin high while the other falls, and then releases the held pin. This separates a design that ignores pin combinations from one that treats the release as a legal edge. It also checks, at specific clock edges, the edge where the new code and the pulse appear, and it checks that clear acts before any clock and does nothing while busy.

// File: rtl/updn_code_stepper.sv
module updn_code_stepper #(
  parameter int CODE_W    = 12,
  parameter int MID_LSB   = 2,
  parameter int COARSE_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_pin,
  input  logic              dn_pin,
  input  logic              cs_pin,
  input  logic              clr_pin,
  input  logic              busy,
  input  logic [1:0]        gran,
  output logic [CODE_W-1:0] code,
  output logic              chg,
  output logic              ser_clr
);
  localparam logic [CODE_W-1:0] ONES = '1;

  logic [2:0] meta_q, sync_q;
  logic [1:0] prev_q;
  logic s_up, s_dn, s_cs;
  logic up_fall, dn_fall, inc, dec;
  logic clr_act, kill_n;
  logic [CODE_W-1:0] unit, fmask, nxt;
  logic sat, step_ok;

  assign clr_act = clr_pin & ~busy;
  assign ser_clr = clr_act;
  assign kill_n  = rst_n & ~clr_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= {cs_pin, dn_pin, up_pin};
      sync_q <= meta_q;
      prev_q <= sync_q[1:0];
    end

  assign s_up = sync_q[0];
  assign s_dn = sync_q[1];
  assign s_cs = sync_q[2];

  assign up_fall = prev_q[0] & ~s_up;
  assign dn_fall = prev_q[1] & ~s_dn;
  assign inc = up_fall & ~prev_q[1] & ~s_dn;
  assign dec = dn_fall & ~prev_q[0] & ~s_up;

  always_comb begin
    unit  = '0;
    fmask = '0;
    unique case (gran)
      2'b00: begin unit[0]          = 1'b1; fmask = ONES; end
      2'b01: begin unit[MID_LSB]    = 1'b1; fmask = ONES << MID_LSB; end
      2'b10: begin unit[COARSE_LSB] = 1'b1; fmask = ONES << COARSE_LSB; end
      default: ;
    endcase
  end

  assign sat     = inc ? ((code & fmask) == fmask) : ((code & fmask) == '0);
  assign step_ok = s_cs & (gran != 2'b11) & (inc | dec) & ~sat;
  assign nxt     = inc ? code + unit : code - unit;

  always_ff @(posedge clk or negedge kill_n)
    if (!kill_n) begin
      code <= '0;
      chg  <= 1'b0;
    end else begin
      chg <= step_ok;
      if (step_ok) code <= nxt;
    end

  AST_MID_LOW_HELD: assert property (@(posedge clk) disable iff (!kill_n)
    $past(gran) == 2'b01 |-> code[MID_LSB-1:0] == $past(code[MID_LSB-1:0])); // R2
  AST_COARSE_LOW_HELD: assert property (@(posedge clk) disable iff (!kill_n)
    $past(gran) == 2'b10 |-> code[COARSE_LSB-1:0] == $past(code[COARSE_LSB-1:0])); // R3
  AST_RESERVED_FROZEN: assert property (@(posedge clk) disable iff (!kill_n)
    gran == 2'b11 |=> $stable(code)); // R4
  AST_DESELECT_FROZEN: assert property (@(posedge clk) disable iff (!kill_n)
    !s_cs |=> $stable(code)); // R6
  AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!kill_n)
    $past(kill_n) && code != $past(code) |-> chg); // R9
  AST_PULSE_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!kill_n)
    chg |-> code != $past(code)); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |-> code == '0 && !chg); // R8
endmodule

// File: tb/sim_updn_code_stepper.sv
module sim_updn_code_stepper;
  localparam int CLK_PER = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_pin = 1'b0, dn_pin = 1'b0, cs_pin = 1'b1, clr_pin = 1'b0, busy = 1'b0;
  logic [1:0] gran = 2'b00;
  logic [11:0] code;
  logic chg, ser_clr;
  int n_chk = 0, n_bad = 0, pulses = 0;

  always #(CLK_PER/2) clk = ~clk;

  updn_code_stepper u0 (
    .clk(clk), .rst_n(rst_n), .up_pin(up_pin), .dn_pin(dn_pin), .cs_pin(cs_pin),
    .clr_pin(clr_pin), .busy(busy), .gran(gran), .code(code), .chg(chg), .ser_clr(ser_clr)
  );

  always @(negedge clk) if (chg) pulses++;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_up(input int hi = 3, input int lo = 6);
    up_pin = 1'b1; waitn(hi); up_pin = 1'b0; waitn(lo);
  endtask

  task automatic pulse_dn();
    dn_pin = 1'b1; waitn(3); dn_pin = 1'b0; waitn(6);
  endtask

  task automatic t_reset();
    check("R8 reset code", code, 12'h000);
    check("R9 reset chg", chg, 0);
    check("R8 reset ser_clr", ser_clr, 0);
  endtask

  task automatic t_fine();
    int p0;
    gran = 2'b00; p0 = pulses;
    pulse_up(); pulse_up(); pulse_up();
    check("R1 three increments", code, 12'h003);
    pulse_dn();
    check("R1 R5 decrement", code, 12'h002);
    check("R9 pulse count", pulses - p0, 4);
  endtask

  task automatic t_latency();
    up_pin = 1'b1; waitn(3); up_pin = 1'b0;
    waitn(2);
    check("R9 code before third edge", code, 12'h002);
    check("R9 chg before third edge", chg, 0);
    waitn(1);
    check("R9 code at third edge", code, 12'h003);
    check("R9 chg at third edge", chg, 1);
    waitn(1);
    check("R9 chg one cycle", chg, 0);
    waitn(4);
  endtask

  task automatic t_mid();
    gran = 2'b01;
    pulse_up();
    check("R2 step by four", code, 12'h007);
    pulse_up();
    check("R2 second step", code, 12'h00B);
    pulse_dn();
    check("R2 low bits kept", code, 12'h007);
  endtask

  task automatic t_coarse_sat();
    int p0;
    gran = 2'b10;
    pulse_up();
    check("R3 step by sixteen", code, 12'h017);
    p0 = pulses;
    for (int i = 0; i < 256; i++) pulse_up(2, 2);
    waitn(6);
    check("R7 R10 saturate at ceiling", code, 12'hFF7);
    check("R9 R10 no pulse when saturated", pulses - p0, 254);
  endtask

  task automatic t_ignored();
    int p0;
    p0 = pulses;
    gran = 2'b11; waitn(2);
    pulse_up();
    check("R4 reserved granularity", code, 12'hFF7);
    gran = 2'b10; cs_pin = 1'b0; waitn(4);
    pulse_dn();
    check("R6 deselected", code, 12'hFF7);
    cs_pin = 1'b1; waitn(4);
    dn_pin = 1'b1; waitn(3);
    pulse_up();
    check("R5 up fall with dn high", code, 12'hFF7);
    check("R5 no pulses while ignored", pulses - p0, 0);
    dn_pin = 1'b0; waitn(6);
    check("R5 dn release decrements", code, 12'hFE7);
  endtask

  task automatic t_clear();
    busy = 1'b1; waitn(1);
    #2 clr_pin = 1'b1; #1;
    check("R8 busy blocks clear", code, 12'hFE7);
    check("R8 busy blocks strobe", ser_clr, 0);
    waitn(2); clr_pin = 1'b0; busy = 1'b0; waitn(1);
    check("R8 code kept after blocked clear", code, 12'hFE7);
    #2 clr_pin = 1'b1; #1;
    check("R8 async clear", code, 12'h000);
    check("R8 strobe", ser_clr, 1);
    waitn(2); clr_pin = 1'b0; waitn(1);
    gran = 2'b00;
    pulse_dn();
    check("R7 floor at zero", code, 12'h000);
  endtask

  initial begin
    waitn(3); rst_n = 1'b1; waitn(2);
    t_reset();
    t_fine();
    t_latency();
    t_mid();
    t_coarse_sat();
    t_ignored();
    t_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule